// File: doc/BRIEF.md
# Interrupt Pin Pending and Remote-IRR Controller

This block keeps the live state of each pin of an interrupt redirection table. Every cycle it samples each pin, applies the pin's polarity and keeps a pending flag. A level-triggered pin also has a remote-IRR flag, which means "delivered, waiting for end of interrupt". The block decides when a pin needs service and hands one service per cycle to a dispatcher. The dispatcher answers in the same cycle whether the interrupt was injected.

The table's configuration fields come in as inputs: vector, polarity, trigger mode and mask. The register block that owns the table also sends a notice when software writes an entry. End-of-interrupt messages arrive with a vector. Every entry whose vector matches gets an acknowledge pulse. A level-type EOI releases the remote-IRR hold-off on each matching pin and re-services any such pin that is still asserted. Reading and writing registers, and resolving destinations, are done outside this block.

Top module: `ipr_pin_ctrl`

## Requirements
- R1: After reset, pending and remote-IRR are clear for every pin, no delivery is requested and no acknowledge is pulsed.
- R2: A pin's effective level is its raw level XOR its polarity bit. An effective rise sets pending at the next clock edge. An effective low clears pending at that edge.
- R3: An edge-triggered pin (trigger bit 0) is serviced when it rises. Once serviced, its pending flag is clear at the following edge, whether or not it is masked.
- R4: A service of an unmasked pin shows as `dlv_valid_o` in the cycle after the edge that captured the request, carrying that pin's index, vector and trigger mode.
- R5: A service of a level-triggered pin (trigger bit 1) sets remote-IRR at the service edge if `dlv_inj_i` is high. If `dlv_inj_i` is low, remote-IRR stays clear.
- R6: A level-triggered pin whose remote-IRR is set is not serviced on a new effective rise.
- R7: An EOI produces, one cycle later, a one-cycle acknowledge pulse on exactly the pins whose vector equals the EOI vector.
- R8: A level-type EOI (`eoi_level_i`=1) clears remote-IRR on the matching pins and re-services each of them that is unmasked and still pending. An edge-type EOI leaves remote-IRR unchanged.
- R9: An entry-write notice for a low-half write (`wr_lo_i`=1) clears that pin's remote-IRR. Any write notice requests service for the pin if it is pending, and for nothing otherwise.
- R10: Outstanding service requests are granted one per cycle, lowest pin index first.
- R11: A masked pin never produces a delivery request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_lvl_i | input | NUM_PINS | Raw pin levels |
| cfg_vec_i | input | NUM_PINS*VEC_W | Vector of each entry, pin i at bits [i*VEC_W +: VEC_W] |
| cfg_pol_i | input | NUM_PINS | Polarity of each entry, 1 = active low |
| cfg_trig_i | input | NUM_PINS | Trigger mode of each entry, 1 = level |
| cfg_mask_i | input | NUM_PINS | Mask of each entry, 1 = masked |
| wr_stb_i | input | 1 | Entry-write notice |
| wr_pin_i | input | PIN_W | Pin whose entry was written |
| wr_lo_i | input | 1 | The write touched the low half of the entry |
| eoi_valid_i | input | 1 | End-of-interrupt message valid |
| eoi_vec_i | input | VEC_W | Vector carried by the EOI |
| eoi_level_i | input | 1 | EOI is for a level-triggered interrupt |
| dlv_inj_i | input | 1 | Dispatcher result for the current request, 1 = injected |
| pend_o | output | NUM_PINS | Pending flags |
| rirr_o | output | NUM_PINS | Remote-IRR flags |
| dlv_valid_o | output | 1 | Delivery request |
| dlv_pin_o | output | PIN_W | Pin being delivered |
| dlv_vec_o | output | VEC_W | Vector being delivered |
| dlv_level_o | output | 1 | Trigger mode of the delivered pin |
| eoi_ack_o | output | NUM_PINS | Per-pin EOI acknowledge pulse |

## Verification
The bench drives an edge pin whose rise comes only from a polarity flip. A design that ignored polarity would never deliver it. It re-raises a level pin while remote-IRR is held, where a design with no hold-off would deliver twice. Several pins share one vector, so an EOI must acknowledge all of them while an edge-type EOI leaves the hold-off alone. It checks that a high-half write re-services a pending pin without releasing remote-IRR, that a refused injection leaves remote-IRR clear, and that a masked edge pin still loses its pending flag. Three pins raised together must come out in ascending order on consecutive cycles; a wrong arbiter would reorder or merge them.

// File: rtl/ipr_pkg.sv
package ipr_pkg;

  localparam int unsigned IPR_DEF_PINS  = 24;
  localparam int unsigned IPR_DEF_VEC_W = 8;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } ipr_trig_e;

endpackage

// File: rtl/ipr_level_sampler.sv
module ipr_level_sampler #(
  parameter int unsigned NUM_PINS = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_lvl_i,
  input  logic [NUM_PINS-1:0] pol_i,
  output logic [NUM_PINS-1:0] eff_o,
  output logic [NUM_PINS-1:0] rise_o
);

  logic [NUM_PINS-1:0] eff_q;
  logic [NUM_PINS-1:0] eff_d;

  always_comb begin
    eff_d = pin_lvl_i ^ pol_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eff_q <= '0;
    end else begin
      eff_q <= eff_d;
    end
  end

  assign eff_o  = eff_d;
  assign rise_o = eff_d & ~eff_q;

endmodule

// File: rtl/ipr_pin_cell.sv
module ipr_pin_cell
  import ipr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic eff_i,
  input  logic rise_i,
  input  logic trig_i,
  input  logic mask_i,
  input  logic grant_i,
  input  logic inj_i,
  input  logic wr_hit_i,
  input  logic wr_lo_i,
  input  logic eoi_hit_i,
  input  logic eoi_level_i,
  output logic pend_o,
  output logic rirr_o,
  output logic svc_o
);

  logic pend_q, pend_d;
  logic rirr_q, rirr_d;
  logic svc_q, svc_d;
  logic is_level;
  logic svc_set;
  logic rirr_set, rirr_clr;

  always_comb begin
    is_level = (ipr_trig_e'(trig_i) == TRIG_LEVEL);

    svc_set = (rise_i && ((!is_level && !pend_q) || !rirr_q))
            || (wr_hit_i && pend_q)
            || (eoi_hit_i && eoi_level_i && !mask_i && pend_q);

    rirr_set = grant_i && !mask_i && inj_i && is_level;
    rirr_clr = (eoi_hit_i && eoi_level_i) || (wr_hit_i && wr_lo_i);

    if (!eff_i) begin
      pend_d = 1'b0;
    end else if (rise_i) begin
      pend_d = 1'b1;
    end else if (grant_i && !is_level) begin
      pend_d = 1'b0;
    end else begin
      pend_d = pend_q;
    end

    if (rirr_set) begin
      rirr_d = 1'b1;
    end else if (rirr_clr) begin
      rirr_d = 1'b0;
    end else begin
      rirr_d = rirr_q;
    end

    if (svc_set) begin
      svc_d = 1'b1;
    end else if (grant_i) begin
      svc_d = 1'b0;
    end else begin
      svc_d = svc_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      rirr_q <= 1'b0;
      svc_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      rirr_q <= rirr_d;
      svc_q  <= svc_d;
    end
  end

  assign pend_o = pend_q;
  assign rirr_o = rirr_q;
  assign svc_o  = svc_q;

  AST_EDGE_PEND_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni) (grant_i && !trig_i && !rise_i) |=> !pend_q); // R3
  AST_RIRR_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(rirr_q) |-> $past(grant_i && trig_i && inj_i && !mask_i)); // R5
  AST_GRANT_RETIRES: assert property (@(posedge clk_i) disable iff (!rst_ni) (grant_i && !rise_i && !wr_hit_i && !eoi_hit_i) |=> !svc_q); // R10

endmodule

// File: rtl/ipr_arbiter.sv
module ipr_arbiter #(
  parameter int unsigned NUM_PINS = 24,
  localparam int unsigned PIN_W = $clog2(NUM_PINS)
) (
  input  logic [NUM_PINS-1:0] req_i,
  output logic [NUM_PINS-1:0] grant_o,
  output logic                any_o,
  output logic [PIN_W-1:0]    idx_o
);

  always_comb begin
    grant_o = '0;
    any_o   = 1'b0;
    idx_o   = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o = PIN_W'(i);
        any_o = 1'b1;
      end
    end
    if (any_o) begin
      grant_o[idx_o] = 1'b1;
    end
  end

endmodule

// File: rtl/ipr_pin_ctrl.sv
module ipr_pin_ctrl
  import ipr_pkg::*;
#(
  parameter int unsigned NUM_PINS = IPR_DEF_PINS,
  parameter int unsigned VEC_W    = IPR_DEF_VEC_W,
  localparam int unsigned PIN_W   = $clog2(NUM_PINS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_PINS-1:0]       pin_lvl_i,
  input  logic [NUM_PINS*VEC_W-1:0] cfg_vec_i,
  input  logic [NUM_PINS-1:0]       cfg_pol_i,
  input  logic [NUM_PINS-1:0]       cfg_trig_i,
  input  logic [NUM_PINS-1:0]       cfg_mask_i,
  input  logic                      wr_stb_i,
  input  logic [PIN_W-1:0]          wr_pin_i,
  input  logic                      wr_lo_i,
  input  logic                      eoi_valid_i,
  input  logic [VEC_W-1:0]          eoi_vec_i,
  input  logic                      eoi_level_i,
  input  logic                      dlv_inj_i,
  output logic [NUM_PINS-1:0]       pend_o,
  output logic [NUM_PINS-1:0]       rirr_o,
  output logic                      dlv_valid_o,
  output logic [PIN_W-1:0]          dlv_pin_o,
  output logic [VEC_W-1:0]          dlv_vec_o,
  output logic                      dlv_level_o,
  output logic [NUM_PINS-1:0]       eoi_ack_o
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_n = rst_sync_q[1];

  logic [NUM_PINS-1:0] eff, rise;
  logic [NUM_PINS-1:0] svc_req, grant;
  logic [NUM_PINS-1:0] wr_hit, eoi_hit;
  logic [NUM_PINS-1:0] ack_q, ack_d;
  logic                grant_any;
  logic [PIN_W-1:0]    grant_idx;

  ipr_level_sampler #(.NUM_PINS(NUM_PINS)) u_sampler (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .pin_lvl_i (pin_lvl_i),
    .pol_i     (cfg_pol_i),
    .eff_o     (eff),
    .rise_o    (rise)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign wr_hit[p]  = wr_stb_i && (wr_pin_i == PIN_W'(p));
    assign eoi_hit[p] = eoi_valid_i && (cfg_vec_i[p*VEC_W +: VEC_W] == eoi_vec_i);

    ipr_pin_cell u_cell (
      .clk_i       (clk_i),
      .rst_ni      (rst_n),
      .eff_i       (eff[p]),
      .rise_i      (rise[p]),
      .trig_i      (cfg_trig_i[p]),
      .mask_i      (cfg_mask_i[p]),
      .grant_i     (grant[p]),
      .inj_i       (dlv_inj_i),
      .wr_hit_i    (wr_hit[p]),
      .wr_lo_i     (wr_lo_i),
      .eoi_hit_i   (eoi_hit[p]),
      .eoi_level_i (eoi_level_i),
      .pend_o      (pend_o[p]),
      .rirr_o      (rirr_o[p]),
      .svc_o       (svc_req[p])
    );
  end

  ipr_arbiter #(.NUM_PINS(NUM_PINS)) u_arb (
    .req_i   (svc_req),
    .grant_o (grant),
    .any_o   (grant_any),
    .idx_o   (grant_idx)
  );

  always_comb begin
    dlv_valid_o = grant_any && !cfg_mask_i[grant_idx];
    dlv_pin_o   = grant_idx;
    dlv_vec_o   = cfg_vec_i[grant_idx*VEC_W +: VEC_W];
    dlv_level_o = cfg_trig_i[grant_idx];
  end

  // acknowledge pulse, one cycle after the EOI
  always_comb begin
    ack_d = eoi_valid_i ? eoi_hit : '0;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= '0;
    end else begin
      ack_q <= ack_d;
    end
  end

  assign eoi_ack_o = ack_q;

  AST_ONE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_n) $onehot0(grant)); // R10
  AST_ACK_FOLLOWS_EOI: assert property (@(posedge clk_i) disable iff (!rst_n) (|eoi_ack_o) |-> $past(eoi_valid_i)); // R7

endmodule

// File: tb/tb_ipr_pin_ctrl.sv
`timescale 1ns/1ps
module tb_ipr_pin_ctrl;

  localparam int N  = 24;
  localparam int VW = 8;
  localparam int PW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0]    pin, pol, trig, mask;
  logic [N*VW-1:0] vec;
  logic            wr_stb, wr_lo, eoi_v, eoi_lvl, inj;
  logic [PW-1:0]   wr_pin;
  logic [VW-1:0]   eoi_vec;
  logic [N-1:0]    pend, rirr, ack;
  logic            dlv_v, dlv_lvl;
  logic [PW-1:0]   dlv_pin;
  logic [VW-1:0]   dlv_vec;

  always #2.5 clk = ~clk;

  ipr_pin_ctrl #(.NUM_PINS(N), .VEC_W(VW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_lvl_i(pin), .cfg_vec_i(vec),
    .cfg_pol_i(pol), .cfg_trig_i(trig), .cfg_mask_i(mask),
    .wr_stb_i(wr_stb), .wr_pin_i(wr_pin), .wr_lo_i(wr_lo),
    .eoi_valid_i(eoi_v), .eoi_vec_i(eoi_vec), .eoi_level_i(eoi_lvl),
    .dlv_inj_i(inj), .pend_o(pend), .rirr_o(rirr), .dlv_valid_o(dlv_v),
    .dlv_pin_o(dlv_pin), .dlv_vec_o(dlv_vec), .dlv_level_o(dlv_lvl),
    .eoi_ack_o(ack)
  );

  typedef struct { int pin; int vec; int lvl; } exp_t;
  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit run_mon = 1'b0;
  bit done = 1'b0;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic push(int p);
    exp_t e;
    e.pin = p;
    e.vec = int'(vec[p*VW +: VW]);
    e.lvl = int'(trig[p]);
    exp_q.push_back(e);
  endtask

  // scoreboard monitor: compares every delivery against the expected queue
  always @(negedge clk) begin
    if (run_mon && dlv_v) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R6/R11 unexpected delivery pin %0d actual 1 expected 0", dlv_pin);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (int'(dlv_pin) != e.pin || int'(dlv_vec) != e.vec || int'(dlv_lvl) != e.lvl) begin
          errors++;
          $display("FAIL R4/R10 delivery actual pin %0d vec 0x%0h lvl %0d expected pin %0d vec 0x%0h lvl %0d",
                   dlv_pin, dlv_vec, dlv_lvl, e.pin, e.vec, e.lvl);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    pin = '0; pol = '0; trig = '0; mask = '1;
    for (int i = 0; i < N; i++) vec[i*VW +: VW] = VW'(8'h20 + i);
    wr_stb = 0; wr_lo = 0; wr_pin = '0; eoi_v = 0; eoi_lvl = 0; eoi_vec = '0; inj = 1;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    run_mon = 1'b1;

    // R1 reset state
    chk("R1 pend", longint'(pend), 0);
    chk("R1 rirr", longint'(rirr), 0);
    chk("R1 dlv", longint'(dlv_v), 0);
    chk("R1 ack", longint'(ack), 0);

    // R3 R4 edge pin 3 unmasked
    mask[3] = 0; push(3); pin[3] = 1;
    step(); chk("R2 pend set pin3", longint'(pend[3]), 1);
    step(); chk("R3 edge pend cleared pin3", longint'(pend[3]), 0);

    // R2 rise from polarity flip alone, pin 5 edge unmasked
    mask[5] = 0; push(5); pol[5] = 1;
    step(); chk("R2 polarity rise pend pin5", longint'(pend[5]), 1);
    step();

    // R2 effective low clears pending, level pin 6 masked
    trig[6] = 1; pin[6] = 1;
    step(); step(); chk("R2 level pend pin6", longint'(pend[6]), 1);
    pin[6] = 0;
    step(); chk("R2 low clears pend pin6", longint'(pend[6]), 0);

    // R11 R3 masked edge pin 7: no delivery, pending still cleared
    pin[7] = 1;
    step(); chk("R11 masked pend pin7", longint'(pend[7]), 1);
    step(); chk("R3 masked edge pend cleared pin7", longint'(pend[7]), 0);

    // R5 level pin 8 delivered and injected; share vector 0x40 with pin 9
    vec[8*VW +: VW] = 8'h40; vec[9*VW +: VW] = 8'h40;
    trig[8] = 1; trig[9] = 1; mask[8] = 0; inj = 1;
    push(8); pin[8] = 1;
    step(); step(); chk("R5 rirr set pin8", longint'(rirr[8]), 1);

    // R6 re-rise while held off: no delivery
    pin[8] = 0; step(); pin[8] = 1;
    step(); step(); step();
    chk("R6 rirr still pin8", longint'(rirr[8]), 1);
    chk("R6 pend pin8", longint'(pend[8]), 1);

    // R7 R8 level EOI on vector 0x40: ack pins 8 and 9, re-service pin 8
    push(8); eoi_vec = 8'h40; eoi_lvl = 1; eoi_v = 1;
    step(); eoi_v = 0;
    chk("R7 ack pins 8 9", longint'(ack), longint'(24'h000300));
    chk("R8 rirr cleared pin8", longint'(rirr[8]), 0);
    step();
    chk("R7 ack one cycle", longint'(ack), 0);
    chk("R8 re-serviced rirr pin8", longint'(rirr[8]), 1);

    // R8 edge-type EOI keeps remote-IRR
    eoi_lvl = 0; eoi_v = 1;
    step(); eoi_v = 0;
    chk("R7 ack edge eoi", longint'(ack), longint'(24'h000300));
    step(); step();
    chk("R8 edge eoi keeps rirr pin8", longint'(rirr[8]), 1);

    // R5 refused injection on level pin 10
    trig[10] = 1; mask[10] = 0; inj = 0; push(10); pin[10] = 1;
    step(); step(); chk("R5 refused rirr pin10", longint'(rirr[10]), 0);
    step();

    // R9 high-half write: re-service, remote-IRR kept
    inj = 1; push(8); wr_pin = PW'(8); wr_lo = 0; wr_stb = 1;
    step(); wr_stb = 0;
    chk("R9 hi write keeps rirr pin8", longint'(rirr[8]), 1);
    step();
    // R9 low-half write with refusal: cleared and stays clear
    inj = 0; push(8); wr_lo = 1; wr_stb = 1;
    step(); wr_stb = 0;
    chk("R9 lo write clears rirr pin8", longint'(rirr[8]), 0);
    step(); chk("R9 refused after lo write pin8", longint'(rirr[8]), 0);
    // R9 write to idle pin 11: nothing
    mask[11] = 0; wr_pin = PW'(11); wr_stb = 1;
    step(); wr_stb = 0; step(); step();
    chk("R9 idle write no pend pin11", longint'(pend[11]), 0);

    // R10 three edge pins together: 2, 12, 20 in order
    inj = 1; mask[2] = 0; mask[12] = 0; mask[20] = 0;
    push(2); push(12); push(20);
    pin[2] = 1; pin[12] = 1; pin[20] = 1;
    step(); chk("R10 all pending", longint'({pend[20], pend[12], pend[2]}), 7);
    repeat (4) step();
    chk("R10 pending drained", longint'({pend[20], pend[12], pend[2]}), 0);

    repeat (3) step();
    chk("R4 R10 expected deliveries left", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule